// File: doc/BRIEF.md
# Conditional-Write Receive Status Register

This block holds an 8-bit receive-condition status register next to an 8-bit snapshot (comparison) register. Hardware event inputs set status bits. A host reaches both registers, and a small interrupt-condition register, over a simple synchronous bus. The bus has one address, a read strobe, a write strobe, write data and registered read data.

Each host read of the status register copies the status value into the snapshot register. A later host write to the status register is checked bit by bit against that snapshot. A bit whose status has moved since the snapshot keeps its value, so an event the host has not yet seen is never lost. Any such blocked bit also raises a sticky write-inhibit flag. The host clears that flag through the interrupt-condition register.

Bit meaning, which is the same in the status and snapshot registers: bit 7 reserved, bit 6 super idle line, bit 5 elastic buffer over/underflow, bit 4 cascade sync error event, bit 3 unknown line state with valid physical layer, bit 2 active line, bit 1 state threshold, bit 0 idle line. Event input `evt_set[i]` drives status bit i.

Top module: `cw_status_pair`

## Requirements
- R1: Reset (synchronous, active high) clears the status register, the snapshot register and the inhibit flag. After reset, reads of all three addresses return 0.
- R2: `rdata` is registered. A read with `rd` high at address 0x0E (status) presents the status value on `rdata` after the next rising edge.
- R3: A read of the status register loads the snapshot register with the status value of that same cycle. Snapshot bit i pairs with status bit i.
- R4: In a status write (`wr` high, address 0x0E), every bit whose status equals its snapshot bit takes the write data, even when other bits in the same write are blocked.
- R5: In a status write, every bit whose status differs from its snapshot bit is neither set nor cleared.
- R6: A status write in which at least one bit mismatches sets the inhibit flag. The flag appears on `wr_inhibit` after the next edge and reads back as bit 0 of the interrupt-condition register at address 0x02.
- R7: The inhibit flag stays set through later matching writes. Only a write to address 0x02 with bit 0 at 1 clears it. Writing 0 to bit 0 leaves it set.
- R8: An event input high in a cycle sets its status bit at the next edge, even if a host status write clears that bit in the same cycle.
- R9: The snapshot register at address 0x1D can be read and written at any time. A direct write replaces the snapshot, and the next status write is checked against the written value.
- R10: A read of an unmapped address returns 0, and a write to an unmapped address changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Host register address |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| evt_set | input | 8 | Hardware event inputs, one per status bit |
| wr_inhibit | output | 1 | Sticky conditional-write-inhibit flag |

## Verification
The bound checker checks the per-cycle rules on every edge:
- events always land in the status register;
- a status write changes only matched bits, and each of them takes the write data;
- a mismatch raises the inhibit flag;
- the flag holds until an explicit clear;
- a status read copies the status into the snapshot;
- reset clears the state.

Only the directed scenarios can show the effects of a sequence of operations. These include a snapshot that is stale because an event arrived after the read, an event that beats a same-cycle clearing write, a snapshot replaced by a direct host write, and the read-data latency and unmapped-address behaviour seen at the bus.

// File: rtl/cwsp_pkg.sv
package cwsp_pkg;
  // Status / snapshot bit positions (both registers share the layout)
  localparam int unsigned BIT_IDLE_LS    = 0;
  localparam int unsigned BIT_THRESHOLD  = 1;
  localparam int unsigned BIT_ACTIVE_LS  = 2;
  localparam int unsigned BIT_UNKNOWN_OK = 3;
  localparam int unsigned BIT_CASCADE    = 4;
  localparam int unsigned BIT_EBUF_ERR   = 5;
  localparam int unsigned BIT_SUPER_IDLE = 6;
  localparam int unsigned BIT_RSVD       = 7;

  // Position of the inhibit flag inside the interrupt-condition register
  localparam int unsigned INH_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_ICR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cwsp_decode.sv
module cwsp_decode
  import cwsp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned STAT_ADDR = 'h0E,
  parameter int unsigned CMP_ADDR  = 'h1D,
  parameter int unsigned ICR_ADDR  = 'h02
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(STAT_ADDR))     sel = SEL_STAT;
    else if (addr == ADDR_W'(CMP_ADDR)) sel = SEL_CMP;
    else if (addr == ADDR_W'(ICR_ADDR)) sel = SEL_ICR;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/cwsp_status.sv
module cwsp_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  input  logic [W-1:0] snap,
  output logic [W-1:0] stat,
  output logic         blocked
);
  logic [W-1:0] diff;
  assign diff    = stat ^ snap;
  assign blocked = wr_en && (diff != '0);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                  stat[i] <= 1'b0;
      else if (evt_set[i])      stat[i] <= 1'b1;
      else if (wr_en && !diff[i]) stat[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/cwsp_snapshot.sv
module cwsp_snapshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_wr,
  input  logic [W-1:0] wdata,
  input  logic         capture,
  input  logic [W-1:0] stat,
  output logic [W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (rst)          snap <= '0;
    else if (host_wr) snap <= wdata;
    else if (capture) snap <= stat;
  end
endmodule

// File: rtl/cwsp_icr.sv
module cwsp_icr
  import cwsp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_inh,
  input  logic         host_wr,
  input  logic [W-1:0] wdata,
  output logic         inh
);
  always_ff @(posedge clk) begin
    if (rst)                           inh <= 1'b0;
    else if (set_inh)                  inh <= 1'b1;
    else if (host_wr && wdata[INH_BIT]) inh <= 1'b0;
  end
endmodule

// File: rtl/cw_status_pair.sv
module cw_status_pair
  import cwsp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned STAT_ADDR = 'h0E,
  parameter int unsigned CMP_ADDR  = 'h1D,
  parameter int unsigned ICR_ADDR  = 'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      evt_set,
  output logic              wr_inhibit
);
  reg_sel_e     sel;
  logic [W-1:0] stat_q;
  logic [W-1:0] snap_q;
  logic         blocked;
  logic [W-1:0] icr_view;
  logic [W-1:0] rd_mux;

  cwsp_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .CMP_ADDR(CMP_ADDR), .ICR_ADDR(ICR_ADDR)
  ) u_dec (
    .addr(addr), .sel(sel)
  );

  cwsp_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst),
    .wr_en(wr && sel == SEL_STAT),
    .wdata(wdata), .evt_set(evt_set),
    .snap(snap_q), .stat(stat_q), .blocked(blocked)
  );

  cwsp_snapshot #(.W(W)) u_snap (
    .clk(clk), .rst(rst),
    .host_wr(wr && sel == SEL_CMP), .wdata(wdata),
    .capture(rd && sel == SEL_STAT), .stat(stat_q),
    .snap(snap_q)
  );

  cwsp_icr #(.W(W)) u_icr (
    .clk(clk), .rst(rst),
    .set_inh(blocked),
    .host_wr(wr && sel == SEL_ICR), .wdata(wdata),
    .inh(wr_inhibit)
  );

  always_comb begin
    icr_view          = '0;
    icr_view[INH_BIT] = wr_inhibit;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_q;
      SEL_CMP:  rd_mux = snap_q;
      SEL_ICR:  rd_mux = icr_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/cwsp_chk.sv
module cwsp_chk
  import cwsp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned STAT_ADDR = 'h0E,
  parameter int unsigned ICR_ADDR  = 'h02
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              wr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      evt_set,
  input logic [W-1:0]      stat,
  input logic [W-1:0]      snap,
  input logic              wr_inhibit
);
  logic at_stat, at_icr;
  assign at_stat = addr == ADDR_W'(STAT_ADDR);
  assign at_icr  = addr == ADDR_W'(ICR_ADDR);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stat == '0 && snap == '0 && !wr_inhibit));

  // R3
  snapshot_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && at_stat) |=> snap == $past(stat));

  // R4
  matched_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && at_stat) |=>
      ((stat ^ $past(wdata)) & ~$past(stat ^ snap) & ~$past(evt_set)) == '0);

  // R5
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && at_stat) |=>
      ((stat ^ $past(stat)) & $past(stat ^ snap) & ~$past(evt_set)) == '0);

  // R6
  inhibit_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && at_stat && stat != snap) |=> wr_inhibit);

  // R7
  inhibit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_inhibit && !(wr && at_icr && wdata[INH_BIT])) |=> wr_inhibit);

  // R8
  event_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> (stat & $past(evt_set)) == $past(evt_set));
endmodule

bind cw_status_pair cwsp_chk #(
  .W(W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ICR_ADDR(ICR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
  .evt_set(evt_set), .stat(stat_q), .snap(snap_q), .wr_inhibit(wr_inhibit)
);

// File: tb/cw_status_pair_bench.sv
`timescale 1ns/1ps
module cw_status_pair_bench;
  localparam logic [4:0] A_STAT = 5'h0E;
  localparam logic [4:0] A_CMP  = 5'h1D;
  localparam logic [4:0] A_ICR  = 5'h02;
  localparam logic [4:0] A_NONE = 5'h05;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, evt_set = '0;
  logic [7:0] rdata;
  logic       wr_inhibit;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cw_status_pair u_cw_status_pair (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .wr_inhibit(wr_inhibit)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, state updates at posedge, sample at next negedge
  task automatic bus_write(input logic [4:0] a, input logic [7:0] d, input logic [7:0] ev = 8'h00);
    addr = a; wdata = d; wr = 1'b1; evt_set = ev;
    @(negedge clk);
    wr = 1'b0; evt_set = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    d = rdata; rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    evt_set = ev;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_read(A_STAT, d); check("R1 status after reset", d, 8'h00);
    bus_read(A_CMP, d);  check("R1 snapshot after reset", d, 8'h00);
    bus_read(A_ICR, d);  check("R1 icr after reset", d, 8'h00);
    check("R1 wr_inhibit after reset", {7'b0, wr_inhibit}, 8'h00);
  endtask

  task automatic t_event_and_snapshot;
    logic [7:0] d;
    pulse_evt(8'hA5);
    bus_read(A_STAT, d); check("R2 R8 status read", d, 8'hA5);
    bus_read(A_CMP, d);  check("R3 snapshot loaded by read", d, 8'hA5);
  endtask

  task automatic t_matched_write;
    logic [7:0] d;
    bus_write(A_STAT, 8'h3C);
    check("R4 no inhibit on matched write", {7'b0, wr_inhibit}, 8'h00);
    bus_read(A_CMP, d);  check("R3 status write leaves snapshot", d, 8'hA5);
    bus_read(A_STAT, d); check("R4 matched write taken", d, 8'h3C);
  endtask

  task automatic t_mismatch_write;
    logic [7:0] d;
    pulse_evt(8'h81);               // status now BD, snapshot 3C
    bus_write(A_STAT, 8'h00);       // bits 7,0 stale -> held
    check("R6 inhibit port raised", {7'b0, wr_inhibit}, 8'h01);
    bus_read(A_ICR, d);  check("R6 icr bit0 raised", d, 8'h01);
    bus_read(A_STAT, d); check("R5 R4 mismatched bits held", d, 8'h81);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    bus_write(A_STAT, 8'h00);       // snapshot 81 matches -> clears
    bus_read(A_STAT, d); check("R4 write after fresh read", d, 8'h00);
    check("R7 flag kept through good write", {7'b0, wr_inhibit}, 8'h01);
    bus_write(A_ICR, 8'h00);
    check("R7 writing 0 keeps flag", {7'b0, wr_inhibit}, 8'h01);
    bus_write(A_ICR, 8'h01);
    check("R7 writing 1 clears flag", {7'b0, wr_inhibit}, 8'h00);
    bus_read(A_ICR, d); check("R7 icr cleared", d, 8'h00);
  endtask

  task automatic t_event_wins;
    logic [7:0] d;
    bus_write(A_STAT, 8'hFB, 8'h04); // snapshot 00 == status; event on bit2
    bus_read(A_STAT, d); check("R8 event beats write", d, 8'hFB | 8'h04);
    check("R8 no inhibit", {7'b0, wr_inhibit}, 8'h00);
    bus_write(A_STAT, 8'h00, 8'h04); // snapshot FF matches, bit2 event again
    bus_read(A_STAT, d); check("R8 event beats clearing write", d, 8'h04);
  endtask

  task automatic t_direct_snapshot;
    logic [7:0] d;
    bus_write(A_CMP, 8'hFF);        // status 04
    bus_read(A_CMP, d); check("R9 snapshot written", d, 8'hFF);
    bus_write(A_STAT, 8'hF0);       // only bit2 matches -> takes 0
    check("R9 inhibit from direct snapshot", {7'b0, wr_inhibit}, 8'h01);
    bus_read(A_STAT, d); check("R9 checked against new snapshot", d, 8'h00);
    bus_write(A_ICR, 8'h01);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_write(A_NONE, 8'hFF);
    bus_read(A_NONE, d); check("R10 unmapped read", d, 8'h00);
    bus_read(A_CMP, d);  check("R10 snapshot untouched", d, 8'h00);
    bus_read(A_STAT, d); check("R10 status untouched", d, 8'h00);
    check("R10 flag untouched", {7'b0, wr_inhibit}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_event_and_snapshot();
    t_matched_write();
    t_mismatch_write();
    t_sticky();
    t_event_wins();
    t_direct_snapshot();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule